// File: doc/BRIEF.md
# Parallel Port Control-Line and Interrupt Unit

This unit sits beside a dual 8-bit parallel port. It watches two control lines per port. The first line of each pair is always an edge-sensitive input. The second line can be an edge input, a handshake strobe, a one-cycle pulse or a fixed level. The unit keeps the direction registers and output latches of both ports. It returns pin/latch mixed data on port reads. It also holds the shared interrupt flag and enable registers that merge control-line events with set pulses from neighbouring timer and shift units.

A one-cycle access strobe carries a 4-bit address, a write flag and write data, and read data is returned combinationally in the same cycle. Register effects take hold at the clock edge that ends the strobe. The control byte is held by the neighbouring register decoder and enters as a level. Its low nibble configures port A and its high nibble configures port B. Control-line inputs are asynchronous and pass through a synchronizer before any edge is judged.

Top module: `pio_handshake_irq`

## Requirements
- R1: Nibble bit 0 (control-byte bit 0 for port A, bit 4 for port B) picks the first-line edge that raises the flag: 1 rising, 0 falling. Flag positions are: port A first line bit 1, port A second line bit 0, port B first line bit 4, port B second line bit 3. A raised flag is visible after the third clock edge following the input change. Synchronizer flops reset to high.
- R2: With second-line field (nibble bits 3:1) 000 or 001 the second line flags on a falling edge, and with 010 or 011 on a rising edge. In these four modes the second-line output enable is low. Fields 1xx never flag the second line.
- R3: A port read (port B address 0x0, port A address 0x1 or 0xF) clears both flags of that port. A port write clears the first-line flag, and clears the second-line flag unless the field is 001 or 011. Flags of the other port and of other sources are untouched.
- R4: Field 100 (handshake): the output is low on entering the mode. It goes low after any port read or write, and goes high after any level change of the first line. When both happen in the same cycle, the access wins.
- R5: Field 101 (pulse): the output is high, and goes low for exactly one clock after each port access (back-to-back accesses hold it low).
- R6: Field 110 drives the second line low and 111 drives it high. The output enable is high in all fields 1xx.
- R7: Address 0x2 holds the port B direction and 0x3 the port A direction. Port data reads return pin bits where direction is 0 and latch bits where it is 1. Latch and direction values appear on the port outputs.
- R8: Flag bits 6, 5 and 2 are set by the T1, T2 and SR set pulses. Writing address 0xD clears every flag whose data bit is 1. A set pulse in the same cycle as its clear wins.
- R9: Writing address 0xE with bit 7 = 1 sets the enables named by bits 6:0, and with bit 7 = 0 clears them. Reading 0xE returns the enables with bit 7 forced to 1.
- R10: irq is high when any flag is set together with its enable. Reading 0xD returns the flags in bits 6:0 and irq in bit 7.
- R11: After reset, flags, enables, latches and directions are zero. Addresses 0x4 to 0xC read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Register access strobe, one cycle per access |
| acc_wr | input | 1 | 1 write, 0 read |
| acc_addr | input | 4 | Register address |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data for the addressed register |
| ctl_byte | input | 8 | Control byte: low nibble port A, high nibble port B |
| pa_pins | input | 8 | Port A pin levels |
| pb_pins | input | 8 | Port B pin levels |
| pa_latch | output | 8 | Port A output latch |
| pa_dir | output | 8 | Port A direction (1 = output) |
| pb_latch | output | 8 | Port B output latch |
| pb_dir | output | 8 | Port B direction (1 = output) |
| ca1_in | input | 1 | Port A first control line |
| ca2_in | input | 1 | Port A second control line, input side |
| cb1_in | input | 1 | Port B first control line |
| cb2_in | input | 1 | Port B second control line, input side |
| ca2_out | output | 1 | Port A second line drive level |
| ca2_oe | output | 1 | Port A second line output enable |
| cb2_out | output | 1 | Port B second line drive level |
| cb2_oe | output | 1 | Port B second line output enable |
| t1_set | input | 1 | Timer 1 flag set pulse |
| t2_set | input | 1 | Timer 2 flag set pulse |
| sr_set | input | 1 | Shift unit flag set pulse |
| irq | output | 1 | Interrupt request, active high |

## Verification
A corrupted flag bit shows on the flag-register read and on irq as soon as its enable is set. Because irq is combinational on the registers, this is the same cycle the bit goes wrong. A stuck handshake or pulse state register shows on the second-line output one clock after the access or first-line change that should have moved it. A wrong synchronizer or edge register shifts the moment a flag appears away from the third clock edge after the input change, or raises a flag for the wrong polarity. The sweeps catch that on the next flag read.

// File: rtl/pio_hs_pkg.sv
// Shared constants and types for the port control-line / interrupt unit.
// Assumes an 8-bit register bus and seven interrupt sources.
package pio_hs_pkg;
    localparam int DATA_W = 8;
    localparam int FLAG_W = 7;

    // Flag/enable bit positions
    localparam int F_CA2 = 0;
    localparam int F_CA1 = 1;
    localparam int F_SR  = 2;
    localparam int F_CB2 = 3;
    localparam int F_CB1 = 4;
    localparam int F_T2  = 5;
    localparam int F_T1  = 6;

    // Register addresses
    localparam logic [3:0] ADR_PB     = 4'h0;
    localparam logic [3:0] ADR_PA     = 4'h1;
    localparam logic [3:0] ADR_DIR_B  = 4'h2;
    localparam logic [3:0] ADR_DIR_A  = 4'h3;
    localparam logic [3:0] ADR_FLAG   = 4'hD;
    localparam logic [3:0] ADR_ENA    = 4'hE;
    localparam logic [3:0] ADR_PA_ALT = 4'hF;

    // Second control line operating modes (nibble bits 3:1)
    typedef enum logic [2:0] {
        L2_FALL_AUTO = 3'b000,
        L2_FALL_KEEP = 3'b001,
        L2_RISE_AUTO = 3'b010,
        L2_RISE_KEEP = 3'b011,
        L2_HANDSHAKE = 3'b100,
        L2_PULSE     = 3'b101,
        L2_FIX_LOW   = 3'b110,
        L2_FIX_HIGH  = 3'b111
    } line2_mode_e;
endpackage

// File: rtl/line_sync.sv
// Synchronizer and change detector for one asynchronous control line.
// Assumes STAGES >= 2. All flops reset to RESET_LVL, so an idle-high line
// produces no change at reset release.
module line_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic changed
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the raw input through the synchronizer, remember last stable level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= {STAGES{RESET_LVL}};
            prev_q <= RESET_LVL;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign level   = sync_q[STAGES-1];
    assign changed = level ^ prev_q;
endmodule

// File: rtl/ctl_pair.sv
// Mode logic for one port's pair of control lines: flag set/clear requests
// and the second-line output in handshake, pulse and fixed-level modes.
// Assumes line levels/changes come already synchronized.
module ctl_pair
    import pio_hs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] nib,
    input  logic       l1_lvl,
    input  logic       l1_chg,
    input  logic       l2_lvl,
    input  logic       l2_chg,
    input  logic       port_rd,
    input  logic       port_wr,
    output logic       l1_set,
    output logic       l2_set,
    output logic       l1_clr,
    output logic       l2_clr,
    output logic       l2_out,
    output logic       l2_oe
);
    line2_mode_e mode;
    logic        port_acc;
    logic        hs_lvl_q;
    logic        pulse_low_q;

    assign mode     = line2_mode_e'(nib[3:1]);
    assign port_acc = port_rd | port_wr;

    // Edge requests: first line by polarity bit, second line only in input modes
    assign l1_set = l1_chg && (l1_lvl == nib[0]);
    assign l2_set = !nib[3] && l2_chg && (l2_lvl == nib[2]);

    // Clear requests from port accesses
    assign l1_clr = port_acc;
    assign l2_clr = port_rd | (port_wr && !(!nib[3] && nib[1]));

    // Handshake level: low on entry and on access, high on first-line change
    always_ff @(posedge clk) begin
        if (!rst_n)                      hs_lvl_q <= 1'b0;
        else if (mode != L2_HANDSHAKE)   hs_lvl_q <= 1'b0;
        else if (port_acc)               hs_lvl_q <= 1'b0;
        else if (l1_chg)                 hs_lvl_q <= 1'b1;
    end

    // Pulse state: low for the one cycle after an access
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_low_q <= 1'b0;
        else        pulse_low_q <= (mode == L2_PULSE) && port_acc;
    end

    // Output level selection per mode
    always_comb begin
        case (mode)
            L2_HANDSHAKE: l2_out = hs_lvl_q;
            L2_PULSE:     l2_out = !pulse_low_q;
            L2_FIX_LOW:   l2_out = 1'b0;
            default:      l2_out = 1'b1;
        endcase
    end

    assign l2_oe = nib[3];

    assert_pulse_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == L2_PULSE && port_acc) |=> !l2_out);

    assert_pulse_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == L2_PULSE && !port_acc) |=> (l2_out || mode != L2_PULSE));

    assert_hs_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == L2_HANDSHAKE && port_acc) |=> (!l2_out || mode != L2_HANDSHAKE));
endmodule

// File: rtl/flag_bank.sv
// Interrupt flag and enable registers with the combined request line.
// Assumes set and clear vectors are one-cycle requests; set wins over clear.
module flag_bank
    import pio_hs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] set_vec,
    input  logic [FLAG_W-1:0] clr_vec,
    input  logic              en_wr,
    input  logic [DATA_W-1:0] en_data,
    output logic [FLAG_W-1:0] flags,
    output logic [FLAG_W-1:0] enables,
    output logic              irq
);
    // Flag update: clear requested bits, then apply set requests
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_vec) | set_vec;
    end

    // Enable update: top data bit chooses set or clear of the named bits
    always_ff @(posedge clk) begin
        if (!rst_n)
            enables <= '0;
        else if (en_wr) begin
            if (en_data[DATA_W-1]) enables <= enables | en_data[FLAG_W-1:0];
            else                   enables <= enables & ~en_data[FLAG_W-1:0];
        end
    end

    assign irq = |(flags & enables);

    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (&clr_vec && set_vec == '0) |=> !irq);

    assert_en_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && en_data[DATA_W-1]) |=>
        ((enables & $past(en_data[FLAG_W-1:0])) == $past(en_data[FLAG_W-1:0])));

    assert_en_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && !en_data[DATA_W-1]) |=>
        ((enables & $past(en_data[FLAG_W-1:0])) == '0));
endmodule

// File: rtl/pio_handshake_irq.sv
// Top of the port control-line / interrupt unit: register decode, port
// latches and directions, read mixing, two control-line pairs, flag bank.
// Assumes one-cycle access strobes; read data is combinational.
module pio_handshake_irq
    import pio_hs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [3:0]        acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    input  logic [DATA_W-1:0] ctl_byte,
    input  logic [DATA_W-1:0] pa_pins,
    input  logic [DATA_W-1:0] pb_pins,
    output logic [DATA_W-1:0] pa_latch,
    output logic [DATA_W-1:0] pa_dir,
    output logic [DATA_W-1:0] pb_latch,
    output logic [DATA_W-1:0] pb_dir,
    input  logic              ca1_in,
    input  logic              ca2_in,
    input  logic              cb1_in,
    input  logic              cb2_in,
    output logic              ca2_out,
    output logic              ca2_oe,
    output logic              cb2_out,
    output logic              cb2_oe,
    input  logic              t1_set,
    input  logic              t2_set,
    input  logic              sr_set,
    output logic              irq
);
    localparam int NPORT = 2;

    logic              wr_hit, rd_hit, sel_pa, sel_pb;
    logic [NPORT-1:0]  port_rd, port_wr;
    logic [NPORT-1:0]  l1_raw, l2_raw, l1_lvl, l1_chg, l2_lvl, l2_chg;
    logic [NPORT-1:0]  l1_set, l2_set, l1_clr, l2_clr, l2_out, l2_oe;
    logic [FLAG_W-1:0] set_vec, clr_vec, flags, enables;
    logic [DATA_W-1:0] pa_mix, pb_mix;

    assign wr_hit  = acc_en &  acc_wr;
    assign rd_hit  = acc_en & ~acc_wr;
    assign sel_pa  = (acc_addr == ADR_PA) || (acc_addr == ADR_PA_ALT);
    assign sel_pb  = (acc_addr == ADR_PB);
    assign port_rd = {rd_hit & sel_pb, rd_hit & sel_pa};
    assign port_wr = {wr_hit & sel_pb, wr_hit & sel_pa};
    assign l1_raw  = {cb1_in, ca1_in};
    assign l2_raw  = {cb2_in, ca2_in};

    // Port latches and direction registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pa_latch <= '0;
            pb_latch <= '0;
            pa_dir   <= '0;
            pb_dir   <= '0;
        end else if (wr_hit) begin
            if (sel_pa)                 pa_latch <= acc_wdata;
            if (sel_pb)                 pb_latch <= acc_wdata;
            if (acc_addr == ADR_DIR_A)  pa_dir   <= acc_wdata;
            if (acc_addr == ADR_DIR_B)  pb_dir   <= acc_wdata;
        end
    end

    // One synchronizer pair and one mode block per port (index 0 = A)
    for (genvar g = 0; g < NPORT; g++) begin : g_port
        line_sync #(.STAGES(SYNC_STAGES), .RESET_LVL(1'b1)) u_sync1 (
            .clk(clk), .rst_n(rst_n), .din(l1_raw[g]),
            .level(l1_lvl[g]), .changed(l1_chg[g]));
        line_sync #(.STAGES(SYNC_STAGES), .RESET_LVL(1'b1)) u_sync2 (
            .clk(clk), .rst_n(rst_n), .din(l2_raw[g]),
            .level(l2_lvl[g]), .changed(l2_chg[g]));
        ctl_pair u_pair (
            .clk(clk), .rst_n(rst_n), .nib(ctl_byte[4*g +: 4]),
            .l1_lvl(l1_lvl[g]), .l1_chg(l1_chg[g]),
            .l2_lvl(l2_lvl[g]), .l2_chg(l2_chg[g]),
            .port_rd(port_rd[g]), .port_wr(port_wr[g]),
            .l1_set(l1_set[g]), .l2_set(l2_set[g]),
            .l1_clr(l1_clr[g]), .l2_clr(l2_clr[g]),
            .l2_out(l2_out[g]), .l2_oe(l2_oe[g]));
    end

    assign ca2_out = l2_out[0];
    assign ca2_oe  = l2_oe[0];
    assign cb2_out = l2_out[1];
    assign cb2_oe  = l2_oe[1];

    // Gather set requests into flag positions
    always_comb begin
        set_vec        = '0;
        set_vec[F_CA2] = l2_set[0];
        set_vec[F_CA1] = l1_set[0];
        set_vec[F_CB2] = l2_set[1];
        set_vec[F_CB1] = l1_set[1];
        set_vec[F_SR]  = sr_set;
        set_vec[F_T2]  = t2_set;
        set_vec[F_T1]  = t1_set;
    end

    // Gather clear requests: port accesses plus direct flag-register writes
    always_comb begin
        clr_vec        = '0;
        clr_vec[F_CA2] = l2_clr[0];
        clr_vec[F_CA1] = l1_clr[0];
        clr_vec[F_CB2] = l2_clr[1];
        clr_vec[F_CB1] = l1_clr[1];
        if (wr_hit && acc_addr == ADR_FLAG)
            clr_vec = clr_vec | acc_wdata[FLAG_W-1:0];
    end

    flag_bank u_flags (
        .clk(clk), .rst_n(rst_n),
        .set_vec(set_vec), .clr_vec(clr_vec),
        .en_wr(wr_hit && acc_addr == ADR_ENA), .en_data(acc_wdata),
        .flags(flags), .enables(enables), .irq(irq));

    assign pa_mix = (pa_pins & ~pa_dir) | (pa_latch & pa_dir);
    assign pb_mix = (pb_pins & ~pb_dir) | (pb_latch & pb_dir);

    // Read data selection
    always_comb begin
        case (acc_addr)
            ADR_PB:     acc_rdata = pb_mix;
            ADR_PA:     acc_rdata = pa_mix;
            ADR_PA_ALT: acc_rdata = pa_mix;
            ADR_DIR_B:  acc_rdata = pb_dir;
            ADR_DIR_A:  acc_rdata = pa_dir;
            ADR_FLAG:   acc_rdata = {irq, flags};
            ADR_ENA:    acc_rdata = {1'b1, enables};
            default:    acc_rdata = '0;
        endcase
    end

    assert_dir_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && acc_addr == ADR_DIR_A) |=> (pa_dir == $past(acc_wdata)));
endmodule

// File: tb/test_pio_handshake_irq.sv
module test_pio_handshake_irq;
    logic       clk = 0, rst_n = 0;
    logic       acc_en = 0, acc_wr = 0;
    logic [3:0] acc_addr = 0;
    logic [7:0] acc_wdata = 0, acc_rdata;
    logic [7:0] ctl_byte = 0, pa_pins = 0, pb_pins = 0;
    logic [7:0] pa_latch, pa_dir, pb_latch, pb_dir;
    logic       ca1_in = 1, ca2_in = 1, cb1_in = 1, cb2_in = 1;
    logic       ca2_out, ca2_oe, cb2_out, cb2_oe;
    logic       t1_set = 0, t2_set = 0, sr_set = 0;
    logic       irq;

    int  n_chk = 0, n_bad = 0;
    bit  done = 0;
    logic [7:0] rd;

    always #10 clk = ~clk;

    pio_handshake_irq i_pio_handshake_irq (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Called at a negedge; drives one access, samples read data mid-cycle
    task automatic acc(input bit wr, input logic [3:0] a, input logic [7:0] d,
                       output logic [7:0] r);
        acc_en = 1; acc_wr = wr; acc_addr = a; acc_wdata = d;
        #5 r = acc_rdata;
        @(negedge clk);
        acc_en = 0; acc_wr = 0;
    endtask

    task automatic set_l1(input int p, input logic v);
        if (p == 0) ca1_in = v; else cb1_in = v;
    endtask
    task automatic set_l2(input int p, input logic v);
        if (p == 0) ca2_in = v; else cb2_in = v;
    endtask
    function automatic logic out2(input int p);
        return (p == 0) ? ca2_out : cb2_out;
    endfunction
    function automatic logic oe2(input int p);
        return (p == 0) ? ca2_oe : cb2_oe;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1;
        tick(1);
        // R11: reset state
        pa_pins = 8'hA5; pb_pins = 8'h3C;
        acc(0, 4'hD, 0, rd); chk("R11 flags", rd, 8'h00);
        acc(0, 4'hE, 0, rd); chk("R11 enables", rd, 8'h80);
        acc(0, 4'h3, 0, rd); chk("R11 dirA", rd, 8'h00);
        chk("R11 latches", {pa_latch, pb_latch, pb_dir}, 24'h0);
        acc(0, 4'h1, 0, rd); chk("R11 portA pins", rd, 8'hA5);
        chk("R11 irq", irq, 0);

        acc(1, 4'hE, 8'hFF, rd);
        // R1/R2: edge flag sweep over ports, modes, first-line polarity
        for (int p = 0; p < 2; p++)
            for (int m = 0; m < 8; m++)
                for (int pol = 0; pol < 2; pol++) begin
                    logic [7:0] b1, b2, e;
                    b1 = (p == 0) ? 8'h02 : 8'h10;
                    b2 = (p == 0) ? 8'h01 : 8'h08;
                    ctl_byte = 8'(((m << 1) | pol) << (4 * p));
                    tick(1);
                    acc(1, 4'hD, 8'h7F, rd);
                    chk("R2 R6 oe", oe2(p), m[2]);
                    set_l1(p, 0); tick(3);
                    e = (pol == 0) ? b1 : 0;
                    acc(0, 4'hD, 0, rd); chk("R1 fall", rd, {e != 0, e[6:0]});
                    acc(1, 4'hD, 8'h7F, rd);
                    set_l1(p, 1); tick(3);
                    e = (pol == 1) ? b1 : 0;
                    acc(0, 4'hD, 0, rd); chk("R1 rise", rd, {e != 0, e[6:0]});
                    acc(1, 4'hD, 8'h7F, rd);
                    set_l2(p, 0); tick(3);
                    e = (m < 4 && m[1] == 0) ? b2 : 0;
                    acc(0, 4'hD, 0, rd); chk("R2 fall", rd, {e != 0, e[6:0]});
                    acc(1, 4'hD, 8'h7F, rd);
                    set_l2(p, 1); tick(3);
                    e = (m < 4 && m[1] == 1) ? b2 : 0;
                    acc(0, 4'hD, 0, rd); chk("R2 rise", rd, {e != 0, e[6:0]});
                end

        // R3: port access clearing in input modes
        for (int p = 0; p < 2; p++)
            for (int m = 0; m < 4; m++)
                for (int wr = 0; wr < 2; wr++) begin
                    logic [7:0] b1, b2, e;
                    logic [3:0] a;
                    b1 = (p == 0) ? 8'h02 : 8'h10;
                    b2 = (p == 0) ? 8'h01 : 8'h08;
                    ctl_byte = 8'(((m << 1) | 1) << (4 * p));
                    tick(1);
                    acc(1, 4'hD, 8'h7F, rd);
                    set_l1(p, 0); set_l2(p, 0); tick(3);
                    set_l1(p, 1); set_l2(p, 1); tick(3);
                    t1_set = 1; tick(1); t1_set = 0;
                    acc(0, 4'hD, 0, rd); chk("R3 before", rd, {1'b1, b1[6:0] | b2[6:0] | 7'h40});
                    a = (p == 1) ? 4'h0 : ((m % 2 == 1) ? 4'hF : 4'h1);
                    acc(wr[0], a, 8'h00, rd);
                    e = 8'h40;
                    if (wr == 1 && (m == 1 || m == 3)) e = e | b2;
                    acc(0, 4'hD, 0, rd); chk("R3 after", rd, {1'b1, e[6:0]});
                end
        acc(1, 4'hD, 8'h7F, rd);

        // R4: handshake
        for (int p = 0; p < 2; p++) begin
            ctl_byte = 8'(8'h08 << (4 * p));
            tick(1);
            chk("R4 entry low", {oe2(p), out2(p)}, 2'b10);
            set_l1(p, 0); tick(3);
            chk("R4 l1 change high", out2(p), 1);
            acc(0, (p == 0) ? 4'h1 : 4'h0, 0, rd);
            chk("R4 read low", out2(p), 0);
            set_l1(p, 1); tick(3);
            chk("R4 l1 change high 2", out2(p), 1);
            acc(1, (p == 0) ? 4'hF : 4'h0, 8'h00, rd);
            chk("R4 write low", out2(p), 0);
            set_l1(p, 0); tick(2);
            acc(0, (p == 0) ? 4'h1 : 4'h0, 0, rd);
            tick(2);
            chk("R4 access wins", out2(p), 0);
            set_l1(p, 1); tick(3);
        end
        acc(1, 4'hD, 8'h7F, rd);

        // R5: pulse
        for (int p = 0; p < 2; p++) begin
            ctl_byte = 8'(8'h0A << (4 * p));
            tick(1);
            chk("R5 idle high", out2(p), 1);
            acc(0, (p == 0) ? 4'h1 : 4'h0, 0, rd);
            chk("R5 low one", out2(p), 0);
            tick(1);
            chk("R5 back high", out2(p), 1);
            acc(1, (p == 0) ? 4'h1 : 4'h0, 0, rd);
            acc(0, (p == 0) ? 4'hF : 4'h0, 0, rd);
            chk("R5 b2b low", out2(p), 0);
            tick(1);
            chk("R5 b2b high", out2(p), 1);
        end

        // R6: fixed levels
        for (int p = 0; p < 2; p++)
            for (int v = 0; v < 2; v++) begin
                ctl_byte = 8'((8'h0C | (v << 1)) << (4 * p));
                tick(1);
                chk("R6 fixed", {oe2(p), out2(p)}, {1'b1, v[0]});
            end
        ctl_byte = 0;
        tick(1);

        // R7: read mixing sweep
        for (int i = 0; i < 16; i++) begin
            logic [7:0] da, db, la, lb;
            da = 8'(i * 17) ^ 8'h3C; db = ~da;
            la = 8'(i * 29 + 7);     lb = 8'(i * 53 + 1);
            pa_pins = 8'(i * 71);    pb_pins = 8'(i * 37 + 90);
            acc(1, 4'h3, da, rd); acc(1, 4'h2, db, rd);
            acc(1, (i % 2) ? 4'hF : 4'h1, la, rd); acc(1, 4'h0, lb, rd);
            chk("R7 outputs", {pa_latch, pa_dir, pb_latch, pb_dir}, {la, da, lb, db});
            acc(0, 4'h1, 0, rd); chk("R7 mixA", rd, (pa_pins & ~da) | (la & da));
            acc(0, 4'hF, 0, rd); chk("R7 mixA alt", rd, (pa_pins & ~da) | (la & da));
            acc(0, 4'h0, 0, rd); chk("R7 mixB", rd, (pb_pins & ~db) | (lb & db));
            acc(0, 4'h2, 0, rd); chk("R7 dirB", rd, db);
        end

        // R8: source pulses and flag-register clearing
        acc(1, 4'hD, 8'h7F, rd);
        t1_set = 1; t2_set = 1; sr_set = 1; tick(1);
        t1_set = 0; t2_set = 0; sr_set = 0;
        acc(0, 4'hD, 0, rd); chk("R8 sources", rd, 8'hE4);
        acc(1, 4'hD, 8'h20, rd);
        acc(0, 4'hD, 0, rd); chk("R8 clear one", rd, 8'hC4);
        t1_set = 1; acc(1, 4'hD, 8'h40, rd); t1_set = 0;
        acc(0, 4'hD, 0, rd); chk("R8 set wins", rd, 8'hC4);
        acc(1, 4'hD, 8'h40, rd);
        acc(0, 4'hD, 0, rd); chk("R8 cleared", rd, 8'h84);
        t1_set = 1; t2_set = 1; tick(1); t1_set = 0; t2_set = 0;

        // R9/R10: enable sweep against flags 0x64
        for (int e = 0; e < 128; e++) begin
            acc(1, 4'hE, 8'h7F, rd);
            acc(1, 4'hE, 8'(8'h80 | e), rd);
            acc(0, 4'hE, 0, rd); chk("R9 enable read", rd, 8'(8'h80 | e));
            acc(0, 4'hD, 0, rd);
            chk("R10 flag read", rd, {((e & 8'h64) != 0), 7'h64});
            chk("R10 irq", irq, ((e & 8'h64) != 0));
        end
        acc(1, 4'hE, 8'hFF, rd);
        acc(1, 4'hE, 8'h24, rd);
        acc(0, 4'hE, 0, rd); chk("R9 clear bits", rd, 8'hDB);

        // R11: unused addresses
        for (int a = 4; a < 13; a++) begin
            acc(0, 4'(a), 0, rd); chk("R11 unused read", rd, 8'h00);
            acc(1, 4'(a), 8'hFF, rd);
        end
        acc(0, 4'hE, 0, rd); chk("R11 enables kept", rd, 8'hDB);
        acc(0, 4'hD, 0, rd); chk("R11 flags kept", rd, 8'hE4);
        chk("R11 regs kept", {pa_dir, pb_dir}, {8'(15 * 17) ^ 8'h3C, ~(8'(15 * 17) ^ 8'h3C)});

        finish_run();
    end
endmodule